// File: doc/BRIEF.md
# DMA Transfer Queue Register Front-End

This block is the software-facing control side of a single-channel DMA engine. Software programs the addresses, lengths, strides and a cyclic flag of a transfer into holding registers over a simple register bus, reads the identifier that hardware will assign to it, and then commits it with a write to a start register. Committed requests wait in a small in-order queue and are offered to the data-moving engine over a valid/ready handshake, each tagged with its identifier.

When the engine reports a finished transfer (a one-cycle done pulse carrying the identifier), the block sets the matching bit of a completion bitmap. Two interrupt causes are kept: one when the engine takes a queued request and so frees a queue slot, and one when a transfer finishes. Each cause has a pending bit that software clears by writing ones, and a mask bit. The single level interrupt output is high while any unmasked cause is pending.

The control register enables the channel and can pause hand-over to the engine. Disabling the channel throws away everything still waiting in the queue.

Top module: `dmaq_regfront`

## Requirements
- R1: After reset the mask register (0x80) reads 3, the pending register (0x84) reads 0, the next-ID register (0x404) reads 0, the start register (0x408) reads 0, `irq` is 0 and `req_valid` is 0.
- R2: A write to the pending register (0x84) clears exactly those pending bits that are 1 in the written value and leaves the others as they were.
- R3: The source register (0x88) reads pending AND NOT mask, where a mask bit of 1 masks its cause, and `irq` is 1 exactly when that value is nonzero; bit 0 is the slot-freed cause and bit 1 the transfer-finished cause.
- R4: Register 0x404 reads the identifier the next accepted submission will receive; each accepted submission increments it modulo 4 (identifiers are 2 bits).
- R5: The queue holds at most 4 requests; register 0x408 reads 1 while it is full and 0 otherwise, and a submission attempted while full is dropped without changing the next identifier.
- R6: Writing a value with bit 0 set to 0x408 while enabled and not full queues the current contents of the holding registers (destination address 0x410, source address 0x414, X length 0x418, Y length 0x41C, destination stride 0x420, source stride 0x424) with the next identifier; the engine receives requests in submission order with those exact values.
- R7: When the engine takes a request (`req_valid` and `req_ready` high on the same edge), pending bit 0 becomes 1.
- R8: A `done_valid` pulse sets the bit of the done bitmap (0x428) indexed by `done_id` and sets pending bit 1; other bitmap bits are unchanged.
- R9: An accepted submission clears the done-bitmap bit of the identifier it receives.
- R10: Bit 0 of the control register (0x400) enables the channel; writing a value with bit 0 clear empties the queue (`req_valid` falls, 0x408 reads 0), and submissions while disabled are ignored.
- R11: While bit 1 of the control register (pause) is set, `req_valid` stays 0 and queued requests are kept.
- R12: Register 0x42C reads the identifier of the request the engine most recently took.
- R13: Bit 0 of the flags register (0x40C) is carried with each request as `req_cyclic`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_rdata | output | 32 | Registered read data |
| req_valid | output | 1 | A request is offered to the engine |
| req_ready | input | 1 | Engine takes the offered request |
| req_dst_addr | output | 32 | Destination address of the offered request |
| req_src_addr | output | 32 | Source address of the offered request |
| req_x_len | output | 32 | X length as written by software |
| req_y_len | output | 32 | Y length as written by software |
| req_dst_stride | output | 32 | Destination stride |
| req_src_stride | output | 32 | Source stride |
| req_cyclic | output | 1 | Request is cyclic |
| req_id | output | 2 | Identifier of the offered request |
| done_valid | input | 1 | One-cycle pulse: a transfer finished |
| done_id | input | 2 | Identifier of the finished transfer |
| irq | output | 1 | Level interrupt, high while an unmasked cause is pending |

## Verification
The bench builds the block with its defaults: a 4-entry queue, 4 identifiers and 2 interrupt causes. With so few states it can fill the queue to the brim and past it, walk the identifier through a full wrap, set and clear every done-bitmap bit, and sweep all 16 combinations of pending and mask values as well as all four clear patterns, each compared against values the bench derives by simple bit arithmetic.

// File: rtl/dmaq_pkg.sv
// Package: register offsets and bit positions shared by the queue front-end.
// Assumes byte addressing on the register bus with 32-bit aligned registers.
package dmaq_pkg;
    localparam int OFF_IRQ_MASK   = 'h080;
    localparam int OFF_IRQ_PEND   = 'h084;
    localparam int OFF_IRQ_SRC    = 'h088;
    localparam int OFF_CTRL       = 'h400;
    localparam int OFF_NEXT_ID    = 'h404;
    localparam int OFF_START      = 'h408;
    localparam int OFF_FLAGS      = 'h40C;
    localparam int OFF_DST_ADDR   = 'h410;
    localparam int OFF_SRC_ADDR   = 'h414;
    localparam int OFF_X_LEN      = 'h418;
    localparam int OFF_Y_LEN      = 'h41C;
    localparam int OFF_DST_STRIDE = 'h420;
    localparam int OFF_SRC_STRIDE = 'h424;
    localparam int OFF_DONE_MAP   = 'h428;
    localparam int OFF_ACTIVE_ID  = 'h42C;

    // Interrupt cause positions in mask, pending and source registers
    localparam int IRQ_BIT_SLOT = 0;
    localparam int IRQ_BIT_FIN  = 1;
    localparam int NUM_IRQ      = 2;

    // Control register bit positions
    localparam int CTRL_BIT_EN    = 0;
    localparam int CTRL_BIT_PAUSE = 1;
endpackage

// File: rtl/dmaq_req_queue.sv
// Request queue: in-order circular buffer of packed requests.
// Assumes DEPTH is a power of two; push while full and pop while empty
// are filtered by the caller. Flush empties the queue in one cycle.
module dmaq_req_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    // Store a pushed entry in the slot under the write pointer
    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            if (push && !pop)      count <= count + CNT_W'(1);
            else if (pop && !push) count <= count - CNT_W'(1);
        end
    end

    assign head_data = slots[rd_ptr];
    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/dmaq_done_map.sv
// Completion bitmap: one bit per transfer identifier.
// A completion sets its bit; a new submission clears the bit of the
// identifier it takes. When both hit the same bit in one cycle, set wins.
module dmaq_done_map #(
    parameter int NUM_IDS = 4,
    parameter int ID_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_valid,
    input  logic [ID_W-1:0]    set_id,
    input  logic               clr_valid,
    input  logic [ID_W-1:0]    clr_id,
    output logic [NUM_IDS-1:0] map
);
    for (genvar b = 0; b < NUM_IDS; b++) begin : g_bit
        // Update one identifier's completion flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map[b] <= 1'b0;
            end else if (set_valid && set_id == ID_W'(b)) begin
                map[b] <= 1'b1;
            end else if (clr_valid && clr_id == ID_W'(b)) begin
                map[b] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dmaq_irq_ctrl.sv
// Interrupt cause logic: mask, pending (write-ones-to-clear) and source.
// Assumes set events are single-cycle; a set in the same cycle as a clear
// of that bit leaves the bit pending. Mask bit 1 hides its cause.
module dmaq_irq_ctrl #(
    parameter int NUM_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cause_set,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_wdata,
    output logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] pending,
    output logic [NUM_SRC-1:0] source,
    output logic               irq
);
    // Mask register, all causes hidden out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= mask_wdata;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        // Pending flag for one cause: set dominates clear
        always_ff @(posedge clk) begin
            if (!rst_n)                      pending[s] <= 1'b0;
            else if (cause_set[s])           pending[s] <= 1'b1;
            else if (clr_we && clr_wdata[s]) pending[s] <= 1'b0;
        end
    end

    assign source = pending & ~mask;
    assign irq    = |source;
endmodule

// File: rtl/dmaq_regfront.sv
// Top: register front-end of a single-channel DMA transfer queue.
// Decodes the register bus, holds the request being programmed, allocates
// identifiers, queues requests toward the engine and tracks completions.
// Assumes one access per cycle, bus_wr and bus_rd never both high.
module dmaq_regfront
    import dmaq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 4,
    parameter int NUM_IDS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [DATA_W-1:0]          req_dst_addr,
    output logic [DATA_W-1:0]          req_src_addr,
    output logic [DATA_W-1:0]          req_x_len,
    output logic [DATA_W-1:0]          req_y_len,
    output logic [DATA_W-1:0]          req_dst_stride,
    output logic [DATA_W-1:0]          req_src_stride,
    output logic                       req_cyclic,
    output logic [$clog2(NUM_IDS)-1:0] req_id,
    input  logic                       done_valid,
    input  logic [$clog2(NUM_IDS)-1:0] done_id,
    output logic                       irq
);
    localparam int ID_W    = $clog2(NUM_IDS);
    localparam int ENTRY_W = 6*DATA_W + 1 + ID_W;
    localparam int CNT_W   = $clog2(DEPTH+1);

    // Holding registers for the request being programmed
    logic [DATA_W-1:0] hold_dst, hold_src, hold_xlen, hold_ylen;
    logic [DATA_W-1:0] hold_dstride, hold_sstride;
    logic              hold_cyclic;
    logic              ctrl_en, ctrl_pause;
    logic [ID_W-1:0]   next_id, active_id;

    // Queue and status wires
    logic [ENTRY_W-1:0] push_entry, head_entry;
    logic               q_empty, q_full;
    logic [CNT_W-1:0]   q_count;
    logic               start_wr, submit, take, flush;
    logic [NUM_IDS-1:0] done_map;
    logic [NUM_IRQ-1:0] irq_mask, irq_pend, irq_src, cause_set;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    assign start_wr = bus_wr && hit(bus_addr, OFF_START);
    assign submit   = start_wr && bus_wdata[0] && ctrl_en && !q_full;
    assign flush    = bus_wr && hit(bus_addr, OFF_CTRL) && !bus_wdata[CTRL_BIT_EN];
    assign req_valid = !q_empty && ctrl_en && !ctrl_pause;
    assign take     = req_valid && req_ready;

    // Capture programmed fields and control bits from register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_dst     <= '0;
            hold_src     <= '0;
            hold_xlen    <= '0;
            hold_ylen    <= '0;
            hold_dstride <= '0;
            hold_sstride <= '0;
            hold_cyclic  <= 1'b0;
            ctrl_en      <= 1'b0;
            ctrl_pause   <= 1'b0;
        end else if (bus_wr) begin
            if (hit(bus_addr, OFF_DST_ADDR))   hold_dst     <= bus_wdata;
            if (hit(bus_addr, OFF_SRC_ADDR))   hold_src     <= bus_wdata;
            if (hit(bus_addr, OFF_X_LEN))      hold_xlen    <= bus_wdata;
            if (hit(bus_addr, OFF_Y_LEN))      hold_ylen    <= bus_wdata;
            if (hit(bus_addr, OFF_DST_STRIDE)) hold_dstride <= bus_wdata;
            if (hit(bus_addr, OFF_SRC_STRIDE)) hold_sstride <= bus_wdata;
            if (hit(bus_addr, OFF_FLAGS))      hold_cyclic  <= bus_wdata[0];
            if (hit(bus_addr, OFF_CTRL)) begin
                ctrl_en    <= bus_wdata[CTRL_BIT_EN];
                ctrl_pause <= bus_wdata[CTRL_BIT_PAUSE];
            end
        end
    end

    // Identifier allocation and record of the last identifier handed over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_id   <= '0;
            active_id <= '0;
        end else begin
            if (submit) next_id   <= next_id + ID_W'(1);
            if (take)   active_id <= req_id;
        end
    end

    assign push_entry = {next_id, hold_cyclic, hold_sstride, hold_dstride,
                         hold_ylen, hold_xlen, hold_src, hold_dst};

    dmaq_req_queue #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) queue_i (
        .clk(clk), .rst_n(rst_n),
        .push(submit), .push_data(push_entry),
        .pop(take), .flush(flush),
        .head_data(head_entry), .empty(q_empty), .full(q_full),
        .count(q_count)
    );

    assign {req_id, req_cyclic, req_src_stride, req_dst_stride,
            req_y_len, req_x_len, req_src_addr, req_dst_addr} = head_entry;

    dmaq_done_map #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) done_i (
        .clk(clk), .rst_n(rst_n),
        .set_valid(done_valid), .set_id(done_id),
        .clr_valid(submit), .clr_id(next_id),
        .map(done_map)
    );

    always_comb begin
        cause_set = '0;
        cause_set[IRQ_BIT_SLOT] = take;
        cause_set[IRQ_BIT_FIN]  = done_valid;
    end

    dmaq_irq_ctrl #(.NUM_SRC(NUM_IRQ)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .cause_set(cause_set),
        .mask_we(bus_wr && hit(bus_addr, OFF_IRQ_MASK)),
        .mask_wdata(bus_wdata[NUM_IRQ-1:0]),
        .clr_we(bus_wr && hit(bus_addr, OFF_IRQ_PEND)),
        .clr_wdata(bus_wdata[NUM_IRQ-1:0]),
        .mask(irq_mask), .pending(irq_pend), .source(irq_src),
        .irq(irq)
    );

    // Registered read multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (1'b1)
                hit(bus_addr, OFF_IRQ_MASK):   bus_rdata <= DATA_W'(irq_mask);
                hit(bus_addr, OFF_IRQ_PEND):   bus_rdata <= DATA_W'(irq_pend);
                hit(bus_addr, OFF_IRQ_SRC):    bus_rdata <= DATA_W'(irq_src);
                hit(bus_addr, OFF_CTRL):       bus_rdata <= DATA_W'({ctrl_pause, ctrl_en});
                hit(bus_addr, OFF_NEXT_ID):    bus_rdata <= DATA_W'(next_id);
                hit(bus_addr, OFF_START):      bus_rdata <= DATA_W'(q_full);
                hit(bus_addr, OFF_FLAGS):      bus_rdata <= DATA_W'(hold_cyclic);
                hit(bus_addr, OFF_DST_ADDR):   bus_rdata <= hold_dst;
                hit(bus_addr, OFF_SRC_ADDR):   bus_rdata <= hold_src;
                hit(bus_addr, OFF_X_LEN):      bus_rdata <= hold_xlen;
                hit(bus_addr, OFF_Y_LEN):      bus_rdata <= hold_ylen;
                hit(bus_addr, OFF_DST_STRIDE): bus_rdata <= hold_dstride;
                hit(bus_addr, OFF_SRC_STRIDE): bus_rdata <= hold_sstride;
                hit(bus_addr, OFF_DONE_MAP):   bus_rdata <= DATA_W'(done_map);
                hit(bus_addr, OFF_ACTIVE_ID):  bus_rdata <= DATA_W'(active_id);
                default:                       bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dmaq_regfront_chk.sv
// Checker: temporal properties of the queue front-end, bound to the top.
// Assumes it observes the top's internal queue, pending and bitmap state.
module dmaq_regfront_chk #(
    parameter int DEPTH   = 4,
    parameter int NUM_IDS = 4,
    parameter int ID_W    = 2,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               done_valid,
    input logic [ID_W-1:0]    done_id,
    input logic [1:0]         pend,
    input logic [NUM_IDS-1:0] done_map,
    input logic               pause,
    input logic [CNT_W-1:0]   q_count,
    input logic               start_wr,
    input logic               q_full,
    input logic               submit,
    input logic [ID_W-1:0]    next_id,
    input logic               flush
);
    assert_take_sets_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> pend[0]);

    assert_done_marks_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (done_map[$past(done_id)] && pend[1]));

    assert_pause_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pause |-> !req_valid);

    assert_depth_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && q_full) |=> $stable(next_id));

    assert_id_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        submit |=> next_id == $past(next_id) + ID_W'(1));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_count == '0 && !req_valid));
endmodule

bind dmaq_regfront dmaq_regfront_chk #(
    .DEPTH(DEPTH), .NUM_IDS(NUM_IDS), .ID_W(ID_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .done_valid(done_valid), .done_id(done_id),
    .pend(irq_pend), .done_map(done_map), .pause(ctrl_pause),
    .q_count(q_count), .start_wr(start_wr), .q_full(q_full),
    .submit(submit), .next_id(next_id), .flush(flush)
);

// File: tb/dmaq_regfront_tb_top.sv
module dmaq_regfront_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [31:0] req_dst_addr, req_src_addr, req_x_len, req_y_len;
    logic [31:0] req_dst_stride, req_src_stride;
    logic        req_cyclic;
    logic [1:0]  req_id;
    logic        done_valid = 1'b0;
    logic [1:0]  done_id = '0;
    logic        irq;

    int checks = 0, errors = 0;
    bit finished = 0;
    int exp_next = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmaq_regfront dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dst_addr(req_dst_addr), .req_src_addr(req_src_addr),
        .req_x_len(req_x_len), .req_y_len(req_y_len),
        .req_dst_stride(req_dst_stride), .req_src_stride(req_src_stride),
        .req_cyclic(req_cyclic), .req_id(req_id),
        .done_valid(done_valid), .done_id(done_id), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 12'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] fv(input int k, input int i);
        return 32'h0100_0000 * (k + 1) + 32'(i) * 32'h10 + 32'(k);
    endfunction

    // Program all holding registers for pattern i, then commit (accepted)
    task automatic submit(input int i);
        for (int k = 0; k < 6; k++) wr('h410 + 4*k, fv(k, i));
        wr('h40C, 32'(i & 1));
        wr('h408, 32'h1);
        exp_next = (exp_next + 1) % 4;
    endtask

    task automatic take_one();
        @(negedge clk); req_ready = 1'b1;
        @(negedge clk); req_ready = 1'b0;
    endtask

    task automatic pulse_done(input int id);
        @(negedge clk); done_valid = 1'b1; done_id = 2'(id);
        @(negedge clk); done_valid = 1'b0;
    endtask

    task automatic make_pending(input int p);
        logic [31:0] v;
        wr('h084, 32'h3);
        if (p[0]) begin submit(7); take_one(); end
        if (p[1]) pulse_done(0);
        rd('h084, v);
        check("R2", "pending setup", v, 32'(p));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int id_k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd('h080, v); check("R1", "mask", v, 32'h3);
        rd('h084, v); check("R1", "pending", v, 0);
        rd('h404, v); check("R1", "next id", v, 0);
        rd('h408, v); check("R1", "start", v, 0);
        check("R1", "irq", 32'(irq), 0);
        check("R1", "req_valid", 32'(req_valid), 0);

        // Fill the queue; R4 identifier read-ahead
        wr('h400, 32'h1);
        for (int i = 0; i < 4; i++) begin
            rd('h404, v); check("R4", "next id before submit", v, 32'(i));
            submit(i);
        end
        rd('h404, v); check("R4", "next id wrapped", v, 0);
        rd('h408, v); check("R5", "start full", v, 1);
        wr('h408, 32'h1);                       // dropped: queue full
        rd('h404, v); check("R5", "id after full submit", v, 0);

        // R11: pause
        wr('h400, 32'h3);
        check("R11", "paused valid", 32'(req_valid), 0);
        wr('h400, 32'h1);
        check("R11", "resumed valid", 32'(req_valid), 1);

        // R6/R13/R7/R12: drain in order
        for (int i = 0; i < 4; i++) begin
            check("R6", "valid", 32'(req_valid), 1);
            check("R6", "dst", req_dst_addr, fv(0, i));
            check("R6", "src", req_src_addr, fv(1, i));
            check("R6", "xlen", req_x_len, fv(2, i));
            check("R6", "ylen", req_y_len, fv(3, i));
            check("R6", "dstride", req_dst_stride, fv(4, i));
            check("R6", "sstride", req_src_stride, fv(5, i));
            check("R6", "id", 32'(req_id), 32'(i));
            check("R13", "cyclic", 32'(req_cyclic), 32'(i & 1));
            wr('h084, 32'h3);
            take_one();
            rd('h084, v); check("R7", "slot pending", v, 1);
            rd('h42C, v); check("R12", "active id", v, 32'(i));
        end
        check("R5", "no fifth entry", 32'(req_valid), 0);
        rd('h408, v); check("R5", "start not full", v, 0);

        // R8: done bitmap accumulates
        wr('h084, 32'h3);
        for (int d = 0; d < 4; d++) begin
            pulse_done(d);
            rd('h428, v); check("R8", "done map", v, 32'((1 << (d + 1)) - 1));
            rd('h084, v); check("R8", "finish pending", v & 32'h2, 32'h2);
        end
        // R9: resubmission clears its own done bit
        id_k = exp_next;
        submit(5);
        rd('h428, v); check("R9", "done bit cleared", v, 32'hF & ~(32'h1 << id_k));
        take_one();

        // R2: every clear pattern on fully pending state
        for (int w = 0; w < 4; w++) begin
            make_pending(3);
            wr('h084, 32'(w));
            rd('h084, v); check("R2", "w1c", v, 32'(3 & ~w));
        end

        // R3: all pending x mask combinations
        for (int p = 0; p < 4; p++) begin
            make_pending(p);
            for (int m = 0; m < 4; m++) begin
                wr('h080, 32'(m));
                rd('h088, v); check("R3", "source", v, 32'(p & ~m));
                check("R3", "irq", 32'(irq), 32'((p & ~m) != 0));
            end
        end

        // R10: disable flushes; submissions ignored while disabled
        submit(1); submit(2);
        check("R10", "valid before flush", 32'(req_valid), 1);
        wr('h400, 32'h0);
        check("R10", "valid after flush", 32'(req_valid), 0);
        rd('h408, v); check("R10", "start after flush", v, 0);
        rd('h404, v); id_k = int'(v);
        check("R10", "id model", v, 32'(exp_next));
        wr('h408, 32'h1);
        rd('h404, v); check("R10", "id while disabled", v, 32'(id_k));
        wr('h400, 32'h1);
        check("R10", "queue empty after enable", 32'(req_valid), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule